// File: doc/BRIEF.md
# Interrupt Gate Dispatch Sequencer

This block carries out the entry sequence of one interrupt for a 32-bit protected-mode core. When `start` is pulsed, it captures the vector, the descriptor-table register, the caller's privilege level and the caller's CS, EIP, EFLAGS, SS and ESP, along with the ring-0 stack pair. It then checks that the 8-byte gate for the vector lies within the table limit. If it does, it fetches the gate through a read port and validates it.

For a valid gate, the block writes the return frame through a write port, one item per cycle. The frame is built on the caller's stack when the privilege level stays the same, and on the ring-0 stack when the caller runs outside ring 0. The handler always runs in ring 0.

At the end, the block raises `done` for one cycle. In that cycle it presents either a fault or the new CS, EIP, SS, ESP and flags for the core to load. It does not fetch code-segment descriptors and does not handle task gates or the return path.

Top module: `gate_dispatch`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` is high from the cycle after an accepted start until the cycle after `done`. A `start` pulse while busy changes no read, write or result.
- R2: The block makes exactly one read, at address base + vector*8. The base is bits 47..16 of `tableReg`.
- R3: When vector*8+7 is greater than the limit in bits 15..0 of `tableReg`, `fault` is high with `done`, and no read and no write take place.
- R4: A fetched gate faults, with no writes, in any of these cases: present (bit 47) is 0; the type in bits 43..40 is not 0x6, 0x7, 0xE or 0xF; bit 44 or any of bits 39..32 is nonzero.
- R5: Type bit 3 set (0xE, 0xF) selects 4-byte pushes with `memWrWide`=1. Type bit 3 clear (0x6, 0x7) selects 2-byte pushes with `memWrWide`=0 and the item's low 16 bits zero-extended on `memWrData`.
- R6: Items are pushed in the order SS, ESP, EFLAGS, CS, EIP, on consecutive cycles. SS and ESP are pushed only on a privilege change. Each push first lowers the stack pointer by the item size, then writes at the lowered address.
- R7: When `curPl` is nonzero, the frame starts from `kernEsp` and `newSs` is `kernSs`; the pushed SS and ESP are the caller's. When `curPl` is 0, the frame starts from `curEsp` and `newSs` is `curSs`.
- R8: `newCs` is gate bits 31..16. `newEip` is {gate bits 63..48, gate bits 15..0} for a 32-bit gate, and the low 16 bits zero-extended for a 16-bit gate. `newEsp` is the stack pointer after the last push.
- R9: `newFlags` equals `curFlags`, except that bit 9 (IF) is cleared when type bit 0 is 0 (interrupt gate). A trap gate (type bit 0 = 1) leaves IF as it was. The pushed EFLAGS is always the caller's value.
- R10: `done` is a one-cycle pulse per accepted start, and `fault` is valid in that cycle. After reset, `busy`, `done`, `memRdReq` and `memWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin dispatch of `vector` |
| vector | input | 8 | Interrupt vector |
| tableReg | input | 48 | Table base (47..16) and limit (15..0) |
| curPl | input | 2 | Caller privilege level |
| curCs | input | 16 | Caller code selector |
| curEip | input | 32 | Caller instruction pointer |
| curFlags | input | 32 | Caller flags |
| curSs | input | 16 | Caller stack selector |
| curEsp | input | 32 | Caller stack pointer |
| kernSs | input | 16 | Ring-0 stack selector |
| kernEsp | input | 32 | Ring-0 stack pointer |
| memRdReq | output | 1 | Gate read request, held until `memRdValid` |
| memRdAddr | output | 32 | Gate address |
| memRdData | input | 64 | Gate contents |
| memRdValid | input | 1 | Read data valid |
| memWrEn | output | 1 | Frame write strobe |
| memWrAddr | output | 32 | Frame write address |
| memWrData | output | 32 | Frame item |
| memWrWide | output | 1 | 1 = 4-byte item, 0 = 2-byte item |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End of sequence, one cycle |
| fault | output | 1 | Entry rejected, valid with `done` |
| newCs | output | 16 | Handler code selector |
| newEip | output | 32 | Handler entry offset |
| newSs | output | 16 | Stack selector after entry |
| newEsp | output | 32 | Stack pointer after entry |
| newFlags | output | 32 | Flags after entry |

## Verification
A stack pointer loaded from the wrong pair shows up at `memWrAddr` in the first push cycle, about four cycles after `start`. A push counter that starts at the wrong item or stops at the wrong one shows up as a wrong write count, or as wrong data in a push cycle, well before `done`. A fault flag that is latched wrongly, or a bad width or gate-kind decode, shows up at the latest in the `done` cycle, through `fault`, `memWrWide`, `newEip` or bit 9 of `newFlags`. The stimulus covers both gate widths, both gate kinds, caller rings zero and nonzero, the limit met exactly and missed by one byte, and each gate rejection cause.

// File: rtl/gate_disp_pkg.sv
package gate_disp_pkg;

  localparam int WORD_W = 32;
  localparam int SEL_W  = 16;
  localparam int GATE_W = 64;
  localparam int IF_BIT = 9;
  localparam int ITEM_W = 3;

  typedef enum logic [ITEM_W-1:0] {
    IT_SS    = 3'd0,
    IT_SP    = 3'd1,
    IT_FLAGS = 3'd2,
    IT_CS    = 3'd3,
    IT_IP    = 3'd4
  } pushItem_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LIMIT,
    ST_FETCH,
    ST_DECODE,
    ST_PUSH,
    ST_DONE
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic      capture;
    logic      gateLoad;
    logic      push;
    pushItem_t item;
  } dpCtrl_t;

  // 8-byte gate, field positions fixed by the table format
  typedef struct packed {
    logic [15:0] offHi;    // 63..48
    logic        present;  // 47
    logic [1:0]  dpl;      // 46..45
    logic        zeroBit;  // 44
    logic [3:0]  kind;     // 43..40
    logic [7:0]  rsvd;     // 39..32
    logic [15:0] sel;      // 31..16
    logic [15:0] offLo;    // 15..0
  } gate_t;

  function automatic logic kindKnown(input logic [3:0] k);
    return (k == 4'h6) || (k == 4'h7) || (k == 4'hE) || (k == 4'hF);
  endfunction

endpackage

// File: rtl/gate_disp_datapath.sv
module gate_disp_datapath
  import gate_disp_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int LIMIT_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    ctrl,
  input  logic [VEC_W-1:0]           vector,
  input  logic [LIMIT_W+WORD_W-1:0]  tableReg,
  input  logic [1:0]                 curPl,
  input  logic [SEL_W-1:0]           curCs,
  input  logic [WORD_W-1:0]          curEip,
  input  logic [WORD_W-1:0]          curFlags,
  input  logic [SEL_W-1:0]           curSs,
  input  logic [WORD_W-1:0]          curEsp,
  input  logic [SEL_W-1:0]           kernSs,
  input  logic [WORD_W-1:0]          kernEsp,
  input  logic [GATE_W-1:0]          memRdData,
  output logic [WORD_W-1:0]          memRdAddr,
  output logic [WORD_W-1:0]          memWrAddr,
  output logic [WORD_W-1:0]          memWrData,
  output logic                       memWrWide,
  output logic                       limitBad,
  output logic                       gateBad,
  output logic                       privChg,
  output logic [SEL_W-1:0]           newCs,
  output logic [SEL_W-1:0]           newSs,
  output logic [WORD_W-1:0]          newEip,
  output logic [WORD_W-1:0]          newEsp,
  output logic [WORD_W-1:0]          newFlags
);

  localparam int OFF_W = VEC_W + 3;
  localparam int CMP_W = (OFF_W > LIMIT_W) ? OFF_W : LIMIT_W;
  localparam logic [WORD_W-1:0] IF_MASK = WORD_W'(1) << IF_BIT;
  localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'(16'hFFFF);

  logic [VEC_W-1:0]   vecQ;
  logic [LIMIT_W-1:0] limitQ;
  logic [WORD_W-1:0]  baseQ;
  logic               privChgQ;
  logic [SEL_W-1:0]   callerCsQ;
  logic [WORD_W-1:0]  callerIpQ;
  logic [WORD_W-1:0]  callerFlagsQ;
  logic [SEL_W-1:0]   callerSsQ;
  logic [WORD_W-1:0]  callerSpQ;
  logic [SEL_W-1:0]   stackSsQ;
  logic [WORD_W-1:0]  spQ;
  gate_t              gateQ;

  logic               enteringOuter;
  logic [OFF_W-1:0]   entryEnd;
  logic [CMP_W-1:0]   endExt;
  logic [CMP_W-1:0]   limExt;
  logic               wide;
  logic [WORD_W-1:0]  step;
  logic [WORD_W-1:0]  spNext;
  logic [WORD_W-1:0]  itemVal;
  logic [WORD_W-1:0]  fullOff;
  logic               unusedDpl;

  assign enteringOuter = (curPl != 2'd0);

  // capture, gate load and stack pointer update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecQ         <= '0;
      limitQ       <= '0;
      baseQ        <= '0;
      privChgQ     <= 1'b0;
      callerCsQ    <= '0;
      callerIpQ    <= '0;
      callerFlagsQ <= '0;
      callerSsQ    <= '0;
      callerSpQ    <= '0;
      stackSsQ     <= '0;
      spQ          <= '0;
      gateQ        <= '0;
    end else begin
      if (ctrl.capture) begin
        vecQ         <= vector;
        limitQ       <= tableReg[LIMIT_W-1:0];
        baseQ        <= tableReg[LIMIT_W+WORD_W-1:LIMIT_W];
        privChgQ     <= enteringOuter;
        callerCsQ    <= curCs;
        callerIpQ    <= curEip;
        callerFlagsQ <= curFlags;
        callerSsQ    <= curSs;
        callerSpQ    <= curEsp;
        stackSsQ     <= enteringOuter ? kernSs : curSs;
        spQ          <= enteringOuter ? kernEsp : curEsp;
      end
      if (ctrl.gateLoad) begin
        gateQ <= gate_t'(memRdData);
      end
      if (ctrl.push) begin
        spQ <= spNext;
      end
    end
  end

  // table bounds
  assign entryEnd  = {vecQ, 3'b111};
  assign endExt    = CMP_W'(entryEnd);
  assign limExt    = CMP_W'(limitQ);
  assign limitBad  = (endExt > limExt);
  assign memRdAddr = baseQ + WORD_W'({vecQ, 3'b000});

  // gate validation
  assign gateBad = !gateQ.present || !kindKnown(gateQ.kind) ||
                   gateQ.zeroBit || (gateQ.rsvd != 8'h00);
  assign privChg = privChgQ;
  assign unusedDpl = ^gateQ.dpl;

  // push path
  assign wide   = gateQ.kind[3];
  assign step   = wide ? WORD_W'(4) : WORD_W'(2);
  assign spNext = spQ - step;

  always_comb begin
    unique case (ctrl.item)
      IT_SS:    itemVal = WORD_W'(callerSsQ);
      IT_SP:    itemVal = callerSpQ;
      IT_FLAGS: itemVal = callerFlagsQ;
      IT_CS:    itemVal = WORD_W'(callerCsQ);
      default:  itemVal = callerIpQ;
    endcase
  end

  assign memWrAddr = spNext;
  assign memWrData = wide ? itemVal : (itemVal & LOW_MASK);
  assign memWrWide = wide;

  // handler state
  assign fullOff  = {gateQ.offHi, gateQ.offLo};
  assign newCs    = gateQ.sel;
  assign newEip   = wide ? fullOff : (fullOff & LOW_MASK);
  assign newSs    = stackSsQ;
  assign newEsp   = spQ;
  assign newFlags = gateQ.kind[0] ? callerFlagsQ : (callerFlagsQ & ~IF_MASK);

  AST_PUSH_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.push && $past(ctrl.push)) |->
      (memWrAddr == $past(memWrAddr) - (memWrWide ? WORD_W'(4) : WORD_W'(2))))
    else $error("consecutive pushes not one item apart"); // R6

  AST_FLAGS_IF_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.push && ctrl.item == IT_FLAGS) |->
      (newFlags[IF_BIT] == (memWrData[IF_BIT] && gateQ.kind[0])))
    else $error("IF in new flags does not follow gate kind"); // R9

endmodule

// File: rtl/gate_disp_control.sv
module gate_disp_control
  import gate_disp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memRdValid,
  input  logic    limitBad,
  input  logic    gateBad,
  input  logic    privChg,
  output dpCtrl_t ctrl,
  output logic    memRdReq,
  output logic    busy,
  output logic    done,
  output logic    fault
);

  localparam pushItem_t FIRST_OUTER = IT_SS;
  localparam pushItem_t FIRST_SAME  = IT_FLAGS;
  localparam pushItem_t LAST_ITEM   = IT_IP;

  seqState_t state;
  seqState_t stateNext;
  pushItem_t pushIdx;
  logic      faultQ;

  always_comb begin
    stateNext     = state;
    ctrl          = '0;
    ctrl.item     = pushIdx;
    memRdReq      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.capture = 1'b1;
          stateNext    = ST_LIMIT;
        end
      end
      ST_LIMIT:  stateNext = limitBad ? ST_DONE : ST_FETCH;
      ST_FETCH: begin
        memRdReq = 1'b1;
        if (memRdValid) begin
          ctrl.gateLoad = 1'b1;
          stateNext     = ST_DECODE;
        end
      end
      ST_DECODE: stateNext = gateBad ? ST_DONE : ST_PUSH;
      ST_PUSH: begin
        ctrl.push = 1'b1;
        if (pushIdx == LAST_ITEM) stateNext = ST_DONE;
      end
      ST_DONE:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pushIdx <= IT_SS;
      faultQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctrl.capture) faultQ <= 1'b0;
      if (state == ST_LIMIT && limitBad) faultQ <= 1'b1;
      if (state == ST_DECODE) begin
        if (gateBad) faultQ <= 1'b1;
        pushIdx <= privChg ? FIRST_OUTER : FIRST_SAME;
      end
      if (ctrl.push) pushIdx <= pushItem_t'(pushIdx + 3'd1);
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = (state == ST_DONE);
  assign fault = faultQ;

  AST_ENTRY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LIMIT) |-> ($past(state) == ST_IDLE))
    else $error("sequence entered while busy"); // R1

  AST_NO_FETCH_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> !limitBad)
    else $error("gate read beyond table limit"); // R3

  AST_NO_PUSH_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.push |-> !faultQ)
    else $error("frame write after a fault"); // R4

  AST_SS_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.push && ctrl.item == IT_SS) |-> privChg)
    else $error("outer stack pushed without ring change"); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done)
    else $error("done held longer than a cycle"); // R10

endmodule

// File: rtl/gate_dispatch.sv
module gate_dispatch
  import gate_disp_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int LIMIT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [VEC_W-1:0]          vector,
  input  logic [LIMIT_W+WORD_W-1:0] tableReg,
  input  logic [1:0]                curPl,
  input  logic [SEL_W-1:0]          curCs,
  input  logic [WORD_W-1:0]         curEip,
  input  logic [WORD_W-1:0]         curFlags,
  input  logic [SEL_W-1:0]          curSs,
  input  logic [WORD_W-1:0]         curEsp,
  input  logic [SEL_W-1:0]          kernSs,
  input  logic [WORD_W-1:0]         kernEsp,
  output logic                      memRdReq,
  output logic [WORD_W-1:0]         memRdAddr,
  input  logic [GATE_W-1:0]         memRdData,
  input  logic                      memRdValid,
  output logic                      memWrEn,
  output logic [WORD_W-1:0]         memWrAddr,
  output logic [WORD_W-1:0]         memWrData,
  output logic                      memWrWide,
  output logic                      busy,
  output logic                      done,
  output logic                      fault,
  output logic [SEL_W-1:0]          newCs,
  output logic [WORD_W-1:0]         newEip,
  output logic [SEL_W-1:0]          newSs,
  output logic [WORD_W-1:0]         newEsp,
  output logic [WORD_W-1:0]         newFlags
);

  dpCtrl_t ctrl;
  logic    limitBad;
  logic    gateBad;
  logic    privChg;

  gate_disp_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .memRdValid (memRdValid),
    .limitBad   (limitBad),
    .gateBad    (gateBad),
    .privChg    (privChg),
    .ctrl       (ctrl),
    .memRdReq   (memRdReq),
    .busy       (busy),
    .done       (done),
    .fault      (fault)
  );

  gate_disp_datapath #(
    .VEC_W   (VEC_W),
    .LIMIT_W (LIMIT_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .vector    (vector),
    .tableReg  (tableReg),
    .curPl     (curPl),
    .curCs     (curCs),
    .curEip    (curEip),
    .curFlags  (curFlags),
    .curSs     (curSs),
    .curEsp    (curEsp),
    .kernSs    (kernSs),
    .kernEsp   (kernEsp),
    .memRdData (memRdData),
    .memRdAddr (memRdAddr),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .memWrWide (memWrWide),
    .limitBad  (limitBad),
    .gateBad   (gateBad),
    .privChg   (privChg),
    .newCs     (newCs),
    .newSs     (newSs),
    .newEip    (newEip),
    .newEsp    (newEsp),
    .newFlags  (newFlags)
  );

  assign memWrEn = ctrl.push;

endmodule

// File: tb/test_gate_dispatch.sv
`timescale 1ns/1ps
module test_gate_dispatch;

  localparam logic [31:0] BASE     = 32'h0010_0000;
  localparam logic [15:0] CUR_CS   = 16'h001B;
  localparam logic [15:0] CUR_SS   = 16'h0023;
  localparam logic [31:0] CUR_ESP  = 32'h0000_7FF0;
  localparam logic [15:0] KERN_SS  = 16'h0010;
  localparam logic [31:0] KERN_ESP = 32'h0009_0000;

  typedef struct packed {
    logic [7:0]  vec;
    logic [15:0] limit;
    logic [1:0]  pl;
    logic        present;
    logic [3:0]  kind;
    logic        junk;
    logic        expFault;
  } row_t;

  localparam int NROWS = 12;
  localparam row_t ROWS [NROWS] = '{
    '{8'h08, 16'h07FF, 2'd3, 1'b1, 4'hE, 1'b0, 1'b0}, // 32-bit int, ring change
    '{8'h08, 16'h07FF, 2'd0, 1'b1, 4'hE, 1'b0, 1'b0}, // 32-bit int, same ring
    '{8'h21, 16'h07FF, 2'd3, 1'b1, 4'hF, 1'b0, 1'b0}, // 32-bit trap, ring change
    '{8'h30, 16'h07FF, 2'd0, 1'b1, 4'h7, 1'b0, 1'b0}, // 16-bit trap, same ring
    '{8'h31, 16'h07FF, 2'd2, 1'b1, 4'h6, 1'b0, 1'b0}, // 16-bit int, ring change
    '{8'hFF, 16'h07FF, 2'd1, 1'b1, 4'hE, 1'b0, 1'b0}, // last byte on limit
    '{8'h00, 16'h0007, 2'd0, 1'b1, 4'hF, 1'b0, 1'b0}, // smallest table
    '{8'h20, 16'h0106, 2'd0, 1'b1, 4'hE, 1'b0, 1'b1}, // one byte past limit
    '{8'h40, 16'h07FF, 2'd3, 1'b0, 4'hE, 1'b0, 1'b1}, // not present
    '{8'h41, 16'h07FF, 2'd3, 1'b1, 4'hC, 1'b0, 1'b1}, // undefined kind
    '{8'h42, 16'h07FF, 2'd0, 1'b1, 4'hE, 1'b1, 1'b1}, // must-be-zero bit set
    '{8'h20, 16'h00FF, 2'd3, 1'b1, 4'hE, 1'b0, 1'b1}  // far past limit
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  vector = '0;
  logic [47:0] tableReg = '0;
  logic [1:0]  curPl = '0;
  logic [15:0] curCs = '0;
  logic [31:0] curEip = '0;
  logic [31:0] curFlags = '0;
  logic [15:0] curSs = '0;
  logic [31:0] curEsp = '0;
  logic [15:0] kernSs = '0;
  logic [31:0] kernEsp = '0;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic [63:0] memRdData = '0;
  logic        memRdValid = 1'b0;
  logic        memWrEn;
  logic [31:0] memWrAddr;
  logic [31:0] memWrData;
  logic        memWrWide;
  logic        busy;
  logic        done;
  logic        fault;
  logic [15:0] newCs;
  logic [31:0] newEip;
  logic [15:0] newSs;
  logic [31:0] newEsp;
  logic [31:0] newFlags;

  gate_dispatch i_gate_dispatch (
    .clk(clk), .rstN(rstN), .start(start), .vector(vector), .tableReg(tableReg),
    .curPl(curPl), .curCs(curCs), .curEip(curEip), .curFlags(curFlags),
    .curSs(curSs), .curEsp(curEsp), .kernSs(kernSs), .kernEsp(kernEsp),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memRdValid(memRdValid), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrWide(memWrWide), .busy(busy), .done(done),
    .fault(fault), .newCs(newCs), .newEip(newEip), .newSs(newSs),
    .newEsp(newEsp), .newFlags(newFlags)
  );

  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int errors = 0;

  logic [63:0] gateWord = '0;
  int          rdCount = 0;
  logic [31:0] rdAddrSeen = '0;
  int          wrCount = 0;
  logic [31:0] wrAddrLog [8];
  logic [31:0] wrDataLog [8];
  logic        wrWideLog [8];
  int          wrCycLog  [8];
  int          doneCount = 0;
  int          cyc = 0;

  // memory model and port monitor, away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    memRdValid <= memRdReq;
    if (memRdReq) begin
      rdCount = rdCount + 1;
      rdAddrSeen = memRdAddr;
      memRdData <= gateWord;
    end
    if (memWrEn) begin
      if (wrCount < 8) begin
        wrAddrLog[wrCount] = memWrAddr;
        wrDataLog[wrCount] = memWrData;
        wrWideLog[wrCount] = memWrWide;
        wrCycLog[wrCount]  = cyc;
      end
      wrCount = wrCount + 1;
    end
    if (done) doneCount = doneCount + 1;
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] offFor(input int r);
    return {(r == 1) ? 16'h0000 : 16'hC0DE, 16'h1000 + 16'(r)};
  endfunction
  function automatic logic [15:0] selFor(input int r);
    return 16'h0008 + 16'(r * 8);
  endfunction
  function automatic logic [31:0] flagsFor(input int r);
    return (r % 3 == 0) ? 32'h0000_08D6 : 32'h0000_0A47;
  endfunction
  function automatic logic [31:0] eipFor(input int r);
    return 32'h0804_8000 + 32'(r * 16);
  endfunction

  task automatic startRow(input int r);
    row_t rw;
    logic [31:0] off;
    rw  = ROWS[r];
    off = offFor(r);
    gateWord = {off[31:16], rw.present, 2'b00, rw.junk, rw.kind, 8'h00, selFor(r), off[15:0]};
    rdCount = 0;
    wrCount = 0;
    doneCount = 0;
    vector   = rw.vec;
    tableReg = {BASE, rw.limit};
    curPl    = rw.pl;
    curCs    = CUR_CS;
    curEip   = eipFor(r);
    curFlags = flagsFor(r);
    curSs    = CUR_SS;
    curEsp   = CUR_ESP;
    kernSs   = KERN_SS;
    kernEsp  = KERN_ESP;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 60; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check("R10", "done seen", {31'b0, done}, 32'd1);
  endtask

  task automatic checkRow(input int r);
    row_t rw;
    bit limFault, priv, wide;
    logic [31:0] step, sp, expData, flg, off;
    logic [31:0] items [5];
    int first, n;
    string tag;
    rw = ROWS[r];
    limFault = (int'(rw.vec) * 8 + 7) > int'(rw.limit);
    tag = limFault ? "R3" : "R4";
    check(tag, $sformatf("fault row %0d", r), {31'b0, fault}, {31'b0, rw.expFault});
    if (limFault) begin
      check("R3", "reads on limit fault", rdCount, 0);
      check("R3", "writes on limit fault", wrCount, 0);
      return;
    end
    check("R2", "read count", rdCount, 1);
    check("R2", "gate address", rdAddrSeen, BASE + 32'(int'(rw.vec) * 8));
    if (rw.expFault) begin
      check("R4", "writes on bad gate", wrCount, 0);
      return;
    end
    priv = (rw.pl != 2'd0);
    wide = rw.kind[3];
    step = wide ? 32'd4 : 32'd2;
    flg  = flagsFor(r);
    off  = offFor(r);
    items[0] = {16'h0000, CUR_SS};
    items[1] = CUR_ESP;
    items[2] = flg;
    items[3] = {16'h0000, CUR_CS};
    items[4] = eipFor(r);
    first = priv ? 0 : 2;
    n = 5 - first;
    check("R6", "write count", wrCount, n);
    sp = priv ? KERN_ESP : CUR_ESP;
    check("R7", "first push address", wrAddrLog[0], sp - step);
    for (int k = 0; k < n && k < 8; k++) begin
      sp = sp - step;
      expData = wide ? items[first + k] : (items[first + k] & 32'h0000_FFFF);
      check("R6", $sformatf("push %0d address", k), wrAddrLog[k], sp);
      check("R5", $sformatf("push %0d data", k), wrDataLog[k], expData);
      check("R5", $sformatf("push %0d width", k), {31'b0, wrWideLog[k]}, {31'b0, wide});
      check("R6", $sformatf("push %0d cycle", k), wrCycLog[k], wrCycLog[0] + k);
    end
    check("R8", "new CS", {16'h0, newCs}, {16'h0, selFor(r)});
    check("R8", "new EIP", newEip, wide ? off : (off & 32'h0000_FFFF));
    check("R8", "new ESP", newEsp, sp);
    check("R7", "new SS", {16'h0, newSs}, {16'h0, priv ? KERN_SS : CUR_SS});
    check("R9", "new flags", newFlags, rw.kind[0] ? flg : (flg & ~32'h0000_0200));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R10)
    check("R10", "busy in reset", {31'b0, busy}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "busy after reset", {31'b0, busy}, 32'd0);
    check("R10", "done after reset", {31'b0, done}, 32'd0);
    check("R10", "read req after reset", {31'b0, memRdReq}, 32'd0);
    check("R10", "write after reset", {31'b0, memWrEn}, 32'd0);

    // vector table walk
    for (int r = 0; r < NROWS; r++) begin
      startRow(r);
      waitDone();
      checkRow(r);
      @(negedge clk);
      check("R10", "done one cycle", {31'b0, done}, 32'd0);
      check("R10", "done count", doneCount, 1);
    end

    // directed: start while busy is ignored (R1)
    startRow(0);
    check("R1", "busy after start", {31'b0, busy}, 32'd1);
    vector = 8'h77;
    curPl  = 2'd0;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    waitDone();
    checkRow(0);
    repeat (10) @(negedge clk);
    check("R1", "one done for two starts", doneCount, 1);
    check("R1", "one read for two starts", rdCount, 1);
    check("R1", "idle after run", {31'b0, busy}, 32'd0);

    // directed: back-to-back after a fault (R3 then valid entry)
    startRow(11);
    waitDone();
    checkRow(11);
    @(negedge clk);
    startRow(4);
    waitDone();
    checkRow(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule